// File: doc/BRIEF.md
# TLB Maintenance Control Unit

This unit sits beside the translation caches of a processor core that keeps separate instruction and data TLBs, each organised as 32 congruence classes. It accepts one maintenance operation at a time over a valid/ready channel. It then drives the actions that follow from it. An entry invalidate turns the effective address into a set index and strobes that set in both TLBs together. A sync operation holds the pipeline while an external handshake input stays high. The unsupported invalidate-all operation is trapped as an illegal instruction. A cache-block-zero operation is checked against the page's write-through (W) and cache-inhibit (I) attributes.

An operation transfers on a rising edge where `op_valid` and `op_ready` are both high. `op_ready` is low while the unit stalls on a sync. During that time the source must hold `op_valid` and all operation fields steady, and nothing is consumed. All action outputs are registered and appear in the cycle after acceptance. The TLB arrays, the page table walk and exception vectoring live elsewhere. To clear both TLBs completely, software issues 32 entry invalidates and steps the set index by one each time.

Top module: `tlb_maint_ctrl`

## Requirements
- R1: Operation codes on `op_code`: 0 no-op, 1 invalidate entry, 2 invalidate all, 3 sync, 4 cache-block-zero, and 5 to 7 no effect. An operation is accepted only on an edge where `op_valid` and `op_ready` are both high.
- R2: An accepted invalidate entry drives `inv_set` in the next cycle from EA bits 15 to 19 in big-endian numbering, which are `op_ea[16:12]` with `op_ea[16]` as the MSB.
- R3: That invalidate pulses `inv_itlb` and `inv_dtlb` together for exactly one cycle, in the cycle after acceptance.
- R4: `inv_done` pulses for one cycle in the cycle after the invalidate strobes.
- R5: While the invalidate strobes are high, `lookup_hit` is forced low. Otherwise it follows `lookup_hit_in`.
- R6: An accepted invalidate all sets `exc_illegal` for one cycle in the next cycle and raises no invalidate strobe.
- R7: An accepted sync with `sync_in` high sets `stall` in the next cycle. While `stall` is high, `op_ready` is low and no operation is accepted.
- R8: `stall` falls in the cycle after an edge that samples `sync_in` low. A sync accepted with `sync_in` low never raises `stall`.
- R9: An accepted cache-block-zero sets `exc_align` for one cycle in the next cycle when W or I is 1. It raises no flag when both are 0.
- R10: The exception flags are zero for an operation that raises no exception, and at most one of them is high in any cycle.
- R11: Stepping the set index through all 32 values strobes each set once, so 32 invalidates cover both TLBs.
- R12: Synchronous active-high reset clears `stall`, the strobes, `inv_done` and both flags, and leaves `op_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 3 | Operation code (R1) |
| op_ea | input | 32 | Effective address |
| pg_w | input | 1 | Page write-through attribute |
| pg_i | input | 1 | Page cache-inhibit attribute |
| sync_in | input | 1 | External sync handshake |
| lookup_hit_in | input | 1 | Hit reported by a TLB lookup this cycle |
| lookup_hit | output | 1 | Lookup hit after invalidate priority |
| inv_itlb | output | 1 | Invalidate strobe to instruction TLB |
| inv_dtlb | output | 1 | Invalidate strobe to data TLB |
| inv_set | output | 5 | Set to invalidate |
| inv_done | output | 1 | Invalidate completed pulse |
| stall | output | 1 | Hold instruction execution |
| exc_illegal | output | 1 | Illegal-instruction exception |
| exc_align | output | 1 | Alignment exception |

## Verification
The hardest situation to reach from the ports is an operation that arrives while the unit is stalled on a sync. The bench raises `sync_in`, issues a sync, and then presents an invalidate that it holds for several cycles. It checks that neither strobe fires and that `op_ready` stays low. It then drops `sync_in` and checks that `stall` falls exactly one cycle later and that the held invalidate completes. The lookup priority is reached by raising `lookup_hit_in` in the very cycle the strobes are high.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_INV_ONE  = 3'd1,
    OP_INV_ALL  = 3'd2,
    OP_SYNC     = 3'd3,
    OP_ZERO_BLK = 3'd4
  } maint_op_e;
endpackage

// File: rtl/tlbm_decode.sv
module tlbm_decode
  import tlbm_pkg::*;
(
  input  logic       accept,
  input  logic [2:0] code,
  output logic       do_inv,
  output logic       do_all,
  output logic       do_sync,
  output logic       do_zero
);
  always_comb begin
    do_inv  = 1'b0;
    do_all  = 1'b0;
    do_sync = 1'b0;
    do_zero = 1'b0;
    if (accept) begin
      case (code)
        OP_INV_ONE:  do_inv  = 1'b1;
        OP_INV_ALL:  do_all  = 1'b1;
        OP_SYNC:     do_sync = 1'b1;
        OP_ZERO_BLK: do_zero = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlbm_inval.sv
module tlbm_inval #(
  parameter int EA_W   = 32,
  parameter int BE_HI  = 15,
  parameter int SET_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_inv,
  input  logic [EA_W-1:0]  ea,
  output logic             strobe_i,
  output logic             strobe_d,
  output logic [SET_W-1:0] set_idx,
  output logic             done
);
  localparam int MSB = EA_W - 1 - BE_HI;
  localparam int LSB = MSB - SET_W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_i <= 1'b0;
      strobe_d <= 1'b0;
      set_idx  <= '0;
      done     <= 1'b0;
    end else begin
      strobe_i <= do_inv;
      strobe_d <= do_inv;
      done     <= strobe_i;
      if (do_inv) set_idx <= ea[MSB:LSB];
    end
  end

  // R3
  inv_origin_chk: assert property (@(posedge clk) disable iff (rst)
    do_inv |=> (strobe_i && strobe_d));
  // R4
  inv_done_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> done);
endmodule

// File: rtl/tlbm_sync.sv
module tlbm_sync (
  input  logic clk,
  input  logic rst,
  input  logic do_sync,
  input  logic sync_in,
  output logic stall
);
  always_ff @(posedge clk) begin
    if (rst)        stall <= 1'b0;
    else if (stall) stall <= sync_in;
    else            stall <= do_sync & sync_in;
  end

  // R7
  sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (do_sync && sync_in) |=> stall);
  // R8
  sync_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !sync_in) |=> !stall);
endmodule

// File: rtl/tlbm_exc.sv
module tlbm_exc (
  input  logic clk,
  input  logic rst,
  input  logic do_all,
  input  logic do_zero,
  input  logic attr_w,
  input  logic attr_i,
  output logic illegal,
  output logic align
);
  always_ff @(posedge clk) begin
    if (rst) begin
      illegal <= 1'b0;
      align   <= 1'b0;
    end else begin
      illegal <= do_all;
      align   <= do_zero & (attr_w | attr_i);
    end
  end

  // R9
  zero_align_chk: assert property (@(posedge clk) disable iff (rst)
    (do_zero && (attr_w || attr_i)) |=> align);
endmodule

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl #(
  parameter int EA_W  = 32,
  parameter int BE_HI = 15,
  parameter int SET_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_code,
  input  logic [EA_W-1:0]  op_ea,
  input  logic             pg_w,
  input  logic             pg_i,
  input  logic             sync_in,
  input  logic             lookup_hit_in,
  output logic             lookup_hit,
  output logic             inv_itlb,
  output logic             inv_dtlb,
  output logic [SET_W-1:0] inv_set,
  output logic             inv_done,
  output logic             stall,
  output logic             exc_illegal,
  output logic             exc_align
);
  logic accept, do_inv, do_all, do_sync, do_zero;

  assign op_ready   = ~stall;
  assign accept     = op_valid & op_ready;
  assign lookup_hit = lookup_hit_in & ~(inv_itlb | inv_dtlb);

  tlbm_decode u_dec (
    .accept(accept), .code(op_code), .do_inv(do_inv),
    .do_all(do_all), .do_sync(do_sync), .do_zero(do_zero));

  tlbm_inval #(.EA_W(EA_W), .BE_HI(BE_HI), .SET_W(SET_W)) u_inv (
    .clk(clk), .rst(rst), .do_inv(do_inv), .ea(op_ea),
    .strobe_i(inv_itlb), .strobe_d(inv_dtlb), .set_idx(inv_set),
    .done(inv_done));

  tlbm_sync u_sync (
    .clk(clk), .rst(rst), .do_sync(do_sync), .sync_in(sync_in),
    .stall(stall));

  tlbm_exc u_exc (
    .clk(clk), .rst(rst), .do_all(do_all), .do_zero(do_zero),
    .attr_w(pg_w), .attr_i(pg_i), .illegal(exc_illegal), .align(exc_align));

  // R10
  exc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_illegal, exc_align}));
  // R6
  illegal_no_inv_chk: assert property (@(posedge clk) disable iff (rst)
    exc_illegal |-> !(inv_itlb || inv_dtlb));
  // R5
  lookup_prio_chk: assert property (@(posedge clk) disable iff (rst)
    inv_itlb |-> !lookup_hit);
  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(stall) |-> !inv_itlb);
endmodule

// File: tb/tlb_maint_ctrl_tb.sv
module tlb_maint_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [2:0] op_code = 3'd0;
  logic [31:0] op_ea = '0;
  logic pg_w = 1'b0, pg_i = 1'b0, sync_in = 1'b0, lookup_hit_in = 1'b0;
  logic lookup_hit, inv_itlb, inv_dtlb, inv_done, stall, exc_illegal, exc_align;
  logic [4:0] inv_set;
  int total = 0, bad = 0;
  logic [31:0] seen;

  always #2 clk = ~clk;

  tlb_maint_ctrl u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {code, ea, w, i, exp_inv, exp_ill, exp_align, exp_set}
  localparam logic [44:0] VEC [9] = '{
    {3'd1, 32'h0001_F000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd31},
    {3'd1, 32'hFFFE_0FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0},
    {3'd1, 32'h0000_5000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd5},
    {3'd2, 32'h0001_F000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0},
    {3'd4, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0},
    {3'd4, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0},
    {3'd4, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0},
    {3'd0, 32'h0001_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0},
    {3'd7, 32'h0001_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0}
  };

  // drive at a negedge; the op is accepted on the next posedge; returns at the following negedge
  task automatic issue(input logic [2:0] c, input logic [31:0] ea, input logic w, input logic i);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_ea = ea; pg_w = w; pg_i = i;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 stall", stall, 0);
    check("R12 ready", op_ready, 1);
    check("R12 flags", {exc_illegal, exc_align, inv_itlb, inv_dtlb, inv_done}, 0);
    rst = 1'b0;

    for (int k = 0; k < 9; k++) begin
      logic [44:0] v;
      v = VEC[k];
      issue(v[44:42], v[41:10], v[9], v[8]);
      check("R3 R1 strobe_i", inv_itlb, v[7]);
      check("R3 strobe_d", inv_dtlb, v[7]);
      if (v[7]) check("R2 set", inv_set, v[4:0]);
      check("R6 illegal", exc_illegal, v[6]);
      check("R9 R10 align", exc_align, v[5]);
      lookup_hit_in = 1'b1; #0.5;
      check("R5 lookup", lookup_hit, !v[7]);
      @(negedge clk);
      lookup_hit_in = 1'b0;
      check("R4 done", inv_done, v[7]);
      check("R3 one-cycle", inv_itlb, 0);
      check("R10 flags clear", {exc_illegal, exc_align}, 0);
    end

    // R11 sweep all 32 sets
    seen = '0;
    for (int s = 0; s < 32; s++) begin
      issue(3'd1, 32'(s) << 12, 1'b0, 1'b0);
      if (inv_itlb && inv_dtlb) seen[inv_set] = 1'b1;
    end
    check("R11 all sets", seen, 32'hFFFF_FFFF);

    // R8 sync with sync_in low: no stall
    sync_in = 1'b0;
    issue(3'd3, 32'h0, 1'b0, 1'b0);
    check("R8 no stall", stall, 0);

    // R7 sync with sync_in high, then held invalidate
    sync_in = 1'b1;
    issue(3'd3, 32'h0, 1'b0, 1'b0);
    check("R7 stall", stall, 1);
    check("R7 ready low", op_ready, 0);
    op_valid = 1'b1; op_code = 3'd1; op_ea = 32'h0000_3000;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check("R7 blocked", {inv_itlb, inv_dtlb}, 0);
      check("R7 still stalled", stall, 1);
    end
    sync_in = 1'b0;
    @(negedge clk);
    check("R8 release", stall, 0);
    check("R8 ready", op_ready, 1);
    @(negedge clk);
    op_valid = 1'b0;
    check("R1 held op done", inv_itlb, 1);
    check("R2 held set", inv_set, 5'd3);
    @(negedge clk);
    check("R1 single accept", inv_itlb, 0);

    // R12 reset during stall
    sync_in = 1'b1;
    issue(3'd3, 32'h0, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R12 reset stall", stall, 0);
    rst = 1'b0; sync_in = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule